// File: doc/BRIEF.md
# Load/Store Address and Byte-Lane Unit

This block sits between the register file and a simple synchronous data memory in a 32-bit byte-addressed processor. For each memory request it forms the effective address from a base value and an offset, which is either a 12-bit unsigned immediate or a register value shifted left. The offset is added or subtracted. The block then decides whether the base register gets an updated value and produces the byte enables and lane-aligned store data for the memory port.

Loads return one cycle after the request. The block keeps the lane position and access size of each issued load for that one cycle, so that it can pull the addressed byte, halfword or word out of the returned data and zero-extend it to 32 bits. The byte order is either little-endian or big-endian. It is captured from a strap input while reset is held and stays fixed until the next reset. A misaligned access or an illegal encoding is reported on a fault output, and that access is suppressed.

Top module: `ls_lane_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the byte order is loaded from `be_strap` (0 = little-endian, 1 = big-endian). After reset `ld_valid` is 0, and with `req_valid` low, `mem_en`, `wb_en` and `acc_fault` are 0.
- R2: With `req_mode`=0 (pre-indexed), `mem_addr` equals the base plus the offset, or the base minus the offset when `req_sub`=1. `wb_en` is 0.
- R3: With `req_mode`=1 (post-indexed), `mem_addr` equals the unmodified base. `wb_en` is 1 and `wb_value` is the base plus or minus the offset.
- R4: With `req_mode`=2 (pre-indexed with update), `mem_addr` and `wb_value` both equal the base plus or minus the offset, and `wb_en` is 1.
- R5: When `req_use_reg`=0 the offset is `req_imm` zero-extended. Otherwise it is `req_roff` shifted left by `req_shamt`. A halfword access (`req_size`=1) that uses a register offset with a nonzero shift raises `acc_fault`.
- R6: A halfword access whose address has bit 0 set, or a word access (`req_size`=2) whose address bits 1:0 are nonzero, raises `acc_fault`. For such an access `mem_en` and `wb_en` are both 0.
- R7: `req_size`=3 or `req_mode`=3 raises `acc_fault`, and the access is suppressed in the same way.
- R8: A byte access with address offset k (address bits 1:0) enables lane k in little-endian order and lane 3-k in big-endian order, where lane j is bits 8j+7:8j. A halfword at offset 0 uses lanes 1:0 in little-endian order and lanes 3:2 in big-endian order; at offset 2 the two orders are swapped. A word access enables all four lanes.
- R9: `mem_we` is 1 only for an accepted store. `mem_wdata` carries the low byte of `req_wdata` repeated in all four lanes for a byte store, the low halfword repeated twice for a halfword store, and `req_wdata` unchanged for a word store.
- R10: One cycle after an accepted load, `ld_valid` is 1 and `ld_data` holds the addressed lanes of `mem_rdata`, moved down to bit 0 and zero-extended. In every other cycle `ld_valid` is 0.
- R11: Changes on `be_strap` while `rst_n` is high have no effect on lane selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| be_strap | input | 1 | Byte-order selection, sampled during reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 illegal |
| req_mode | input | 2 | 0 pre, 1 post, 2 pre with update, 3 illegal |
| req_sub | input | 1 | Subtract the offset instead of adding it |
| req_use_reg | input | 1 | Use the register offset instead of the immediate |
| req_imm | input | 12 | Unsigned immediate offset |
| req_base | input | 32 | Base register value |
| req_roff | input | 32 | Register offset value |
| req_shamt | input | 5 | Left shift applied to the register offset |
| req_wdata | input | 32 | Store data, right-aligned |
| mem_rdata | input | 32 | Memory read data, one cycle after `mem_en` |
| acc_fault | output | 1 | Misaligned or illegal request |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Effective byte address |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Lane-aligned store data |
| wb_en | output | 1 | Base register update strobe |
| wb_value | output | 32 | New base value |
| ld_valid | output | 1 | Load result present |
| ld_data | output | 32 | Zero-extended load result |

## Verification
A wrong latched byte order would place every sub-word access in the mirror lanes. This shows on `mem_be` in the same cycle as the request, for any byte or halfword access. Corrupted load bookkeeping, meaning a wrong stored lane position or size, would not show at request time. It would appear only in `ld_data` one cycle later, as the wrong bytes or as unmasked upper bits. Random requests in both byte orders are therefore paired with random read data and checked in that following cycle.

// File: rtl/ls_lane_pkg.sv
// Shared encodings for the load/store lane unit.
// Assumes a 2-bit size field and a 2-bit indexing-mode field.
package ls_lane_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        IDX_PRE    = 2'd0,
        IDX_POST   = 2'd1,
        IDX_PRE_WB = 2'd2,
        IDX_RSVD   = 2'd3
    } idx_mode_e;
endpackage

// File: rtl/ls_addr_gen.sv
// Effective-address generator: forms the offset, the base +/- offset sum,
// picks the access address by indexing mode, and flags faults.
// Assumes power-of-two lane count; sizes above LANE_W are illegal.
module ls_addr_gen
    import ls_lane_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int IMM_W   = 12,
    parameter int SHAMT_W = 5,
    parameter int LANE_W  = 2
) (
    input  logic [ADDR_W-1:0]  base,
    input  logic               use_reg,
    input  logic [IMM_W-1:0]   imm,
    input  logic [ADDR_W-1:0]  roff,
    input  logic [SHAMT_W-1:0] shamt,
    input  logic               sub,
    input  logic [1:0]         size,
    input  logic [1:0]         mode,
    output logic [ADDR_W-1:0]  addr,
    output logic [ADDR_W-1:0]  sum,
    output logic               fault,
    output logic               wb_req
);
    logic [ADDR_W-1:0] offset;
    logic [LANE_W-1:0] span_m1;
    logic              size_ok, misal, scale_bad, mode_bad;

    // Offset selection and address arithmetic.
    always_comb begin
        offset = use_reg ? (roff << shamt) : ADDR_W'(imm);
        sum    = sub ? (base - offset) : (base + offset);
        addr   = (idx_mode_e'(mode) == IDX_POST) ? base : sum;
        wb_req = (idx_mode_e'(mode) == IDX_POST) || (idx_mode_e'(mode) == IDX_PRE_WB);
    end

    // Alignment mask: low address bits that must be zero for this size.
    always_comb begin
        for (int i = 0; i < LANE_W; i++) span_m1[i] = (i < int'(size));
    end

    // Fault detection: illegal encodings, bad scaling, misalignment.
    always_comb begin
        size_ok   = int'(size) <= LANE_W;
        mode_bad  = idx_mode_e'(mode) == IDX_RSVD;
        scale_bad = (acc_size_e'(size) == SZ_HALF) && use_reg && (shamt != '0);
        misal     = |(addr[LANE_W-1:0] & span_m1);
        fault     = !size_ok || mode_bad || scale_bad || misal;
    end
endmodule

// File: rtl/ls_lane_steer.sv
// Store-side lane steering: computes the lowest lane of the access from
// the address offset and byte order, the byte enables and replicated data.
// Assumes illegal sizes are already flagged upstream; they are clipped here.
module ls_lane_steer #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 2
) (
    input  logic [LANE_W-1:0] low,
    input  logic [1:0]        size,
    input  logic              big_end,
    input  logic [DATA_W-1:0] wdata,
    output logic [LANE_W-1:0] lane_pos,
    output logic [LANE_W:0]   nbytes,
    output logic [DATA_W/8-1:0] be,
    output logic [DATA_W-1:0] wdata_out
);
    localparam int LANES = DATA_W / 8;

    logic [1:0]      sz_c;
    logic [LANE_W:0] pos_w;

    // Lane count and starting lane for the chosen byte order.
    always_comb begin
        sz_c     = (int'(size) > LANE_W) ? 2'(LANE_W) : size;
        nbytes   = (LANE_W+1)'(1) << sz_c;
        pos_w    = big_end ? ((LANE_W+1)'(LANES) - nbytes - {1'b0, low}) : {1'b0, low};
        lane_pos = pos_w[LANE_W-1:0];
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [LANE_W-1:0] sel;
        // Enable and replicated data for lane i.
        always_comb begin
            be[i] = ({1'b0, lane_pos} <= (LANE_W+1)'(i)) &&
                    ((LANE_W+1)'(i) < ({1'b0, lane_pos} + nbytes));
            sel   = LANE_W'(i) & (nbytes[LANE_W-1:0] - 1'b1);
            wdata_out[8*i +: 8] = wdata[8*sel +: 8];
        end
    end
endmodule

// File: rtl/ls_load_extract.sv
// Load return path: remembers lane position and size of an issued load
// for one cycle, then shifts the read data down and zero-extends it.
// Assumes memory read data arrives exactly one cycle after the request.
module ls_load_extract #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [LANE_W-1:0] lane_pos,
    input  logic [LANE_W:0]   nbytes,
    input  logic [DATA_W-1:0] rdata,
    output logic              ld_valid,
    output logic [DATA_W-1:0] ld_data
);
    localparam int LANES = DATA_W / 8;

    logic              pend_q;
    logic [LANE_W-1:0] pos_q;
    logic [LANE_W:0]   nb_q;
    logic [DATA_W-1:0] shifted;

    // Capture load shape for the cycle in which data returns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            pos_q  <= '0;
            nb_q   <= '0;
        end else begin
            pend_q <= issue;
            pos_q  <= lane_pos;
            nb_q   <= nbytes;
        end
    end

    // Shift addressed lanes down to bit 0.
    always_comb shifted = rdata >> {pos_q, 3'b000};

    for (genvar i = 0; i < LANES; i++) begin : g_mask
        // Zero every lane above the access size.
        always_comb ld_data[8*i +: 8] = ((LANE_W+1)'(i) < nb_q) ? shifted[8*i +: 8] : 8'h00;
    end

    assign ld_valid = pend_q;

    // R10
    zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid && (nb_q == (LANE_W+1)'(1)) |-> (ld_data[DATA_W-1:8] == '0));
endmodule

// File: rtl/ls_lane_unit.sv
// Top of the load/store address and byte-lane unit. Combines address
// generation, store steering and load extraction, and holds the byte
// order captured during reset. Assumes a single-cycle-latency memory.
module ls_lane_unit #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int IMM_W  = 12,
    localparam int LANES   = DATA_W / 8,
    localparam int LANE_W  = $clog2(LANES),
    localparam int SHAMT_W = $clog2(DATA_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               be_strap,
    input  logic               req_valid,
    input  logic               req_store,
    input  logic [1:0]         req_size,
    input  logic [1:0]         req_mode,
    input  logic               req_sub,
    input  logic               req_use_reg,
    input  logic [IMM_W-1:0]   req_imm,
    input  logic [ADDR_W-1:0]  req_base,
    input  logic [ADDR_W-1:0]  req_roff,
    input  logic [SHAMT_W-1:0] req_shamt,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic               acc_fault,
    output logic               mem_en,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [LANES-1:0]   mem_be,
    output logic [DATA_W-1:0]  mem_wdata,
    output logic               wb_en,
    output logic [ADDR_W-1:0]  wb_value,
    output logic               ld_valid,
    output logic [DATA_W-1:0]  ld_data
);
    logic              be_mode;
    logic              fault, wb_req;
    logic [LANE_W-1:0] lane_pos;
    logic [LANE_W:0]   nbytes;

    // Byte order is taken from the strap only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) be_mode <= be_strap;
    end

    ls_addr_gen #(
        .ADDR_W(ADDR_W), .IMM_W(IMM_W), .SHAMT_W(SHAMT_W), .LANE_W(LANE_W)
    ) addr_i (
        .base(req_base), .use_reg(req_use_reg), .imm(req_imm), .roff(req_roff),
        .shamt(req_shamt), .sub(req_sub), .size(req_size), .mode(req_mode),
        .addr(mem_addr), .sum(wb_value), .fault(fault), .wb_req(wb_req)
    );

    ls_lane_steer #(.DATA_W(DATA_W), .LANE_W(LANE_W)) steer_i (
        .low(mem_addr[LANE_W-1:0]), .size(req_size), .big_end(be_mode),
        .wdata(req_wdata), .lane_pos(lane_pos), .nbytes(nbytes),
        .be(mem_be), .wdata_out(mem_wdata)
    );

    // Request gating: faults suppress both the access and the base update.
    always_comb begin
        acc_fault = req_valid && fault;
        mem_en    = req_valid && !fault;
        mem_we    = mem_en && req_store;
        wb_en     = mem_en && wb_req;
    end

    ls_load_extract #(.DATA_W(DATA_W), .LANE_W(LANE_W)) load_i (
        .clk(clk), .rst_n(rst_n), .issue(mem_en && !req_store),
        .lane_pos(lane_pos), .nbytes(nbytes), .rdata(mem_rdata),
        .ld_valid(ld_valid), .ld_data(ld_data)
    );

    // R8
    lane_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> ($countones(mem_be) == (1 << req_size)));

    // R6
    aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> !((req_size == 2'd1 && mem_addr[0]) ||
                     (req_size == 2'd2 && mem_addr[1:0] != 2'b00)));

    // R4
    wb_same_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en && (req_mode == 2'd2) |-> (mem_addr == wb_value));

    // R11
    order_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(be_mode));
endmodule

// File: tb/ls_lane_unit_tb.sv
// Bench for ls_lane_unit: directed corner cases plus seeded random requests,
// compared against reference functions written from the requirements.
module ls_lane_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        be_strap = 1'b0;
    logic        req_valid = 1'b0, req_store = 1'b0, req_sub = 1'b0, req_use_reg = 1'b0;
    logic [1:0]  req_size = 2'd0, req_mode = 2'd0;
    logic [11:0] req_imm = '0;
    logic [31:0] req_base = '0, req_roff = '0, req_wdata = '0, mem_rdata = '0;
    logic [4:0]  req_shamt = '0;
    logic        acc_fault, mem_en, mem_we, wb_en, ld_valid;
    logic [31:0] mem_addr, mem_wdata, wb_value, ld_data;
    logic [3:0]  mem_be;
    int checks = 0, errors = 0;
    logic order_be = 1'b0;

    always #2.5 clk = ~clk;

    ls_lane_unit dut_i (
        .clk, .rst_n, .be_strap, .req_valid, .req_store, .req_size, .req_mode,
        .req_sub, .req_use_reg, .req_imm, .req_base, .req_roff, .req_shamt,
        .req_wdata, .mem_rdata, .acc_fault, .mem_en, .mem_we, .mem_addr,
        .mem_be, .mem_wdata, .wb_en, .wb_value, .ld_valid, .ld_data
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Lowest lane of the access per R8.
    function automatic int start_lane(input logic [1:0] sz, input logic [1:0] k, input logic big);
        if (!big) return int'(k);
        case (sz)
            2'd0: return 3 - int'(k);
            2'd1: return k[1] ? 0 : 2;
            default: return 0;
        endcase
    endfunction

    function automatic logic [3:0] exp_be(input logic [1:0] sz, input int s);
        case (sz)
            2'd0: return 4'b0001 << s;
            2'd1: return 4'b0011 << s;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [31:0] exp_wd(input logic [1:0] sz, input logic [31:0] w);
        case (sz)
            2'd0: return {4{w[7:0]}};
            2'd1: return {2{w[15:0]}};
            default: return w;
        endcase
    endfunction

    function automatic logic [31:0] exp_ld(input logic [1:0] sz, input int s, input logic [31:0] rd);
        case (sz)
            2'd0: return {24'h0, rd[8*s +: 8]};
            2'd1: return {16'h0, rd[8*s +: 16]};
            default: return rd;
        endcase
    endfunction

    task automatic do_op(input string tag, input logic st, input logic [1:0] sz, input logic [1:0] md,
                         input logic sb, input logic ur, input logic [11:0] im, input logic [31:0] ro,
                         input logic [4:0] sh, input logic [31:0] bs, input logic [31:0] wd);
        logic [31:0] off, sm, ad, rd;
        logic flt, wbe;
        int s;
        off = ur ? (ro << sh) : {20'h0, im};
        sm  = sb ? bs - off : bs + off;
        ad  = (md == 2'd1) ? bs : sm;
        flt = (sz == 2'd3) || (md == 2'd3) || (sz == 2'd1 && ur && sh != 0) ||
              (sz == 2'd1 && ad[0]) || (sz == 2'd2 && ad[1:0] != 0);
        wbe = !flt && (md == 2'd1 || md == 2'd2);
        s   = start_lane(sz, ad[1:0], order_be);
        @(negedge clk);
        req_valid = 1'b1; req_store = st; req_size = sz; req_mode = md; req_sub = sb;
        req_use_reg = ur; req_imm = im; req_roff = ro; req_shamt = sh; req_base = bs; req_wdata = wd;
        #1;
        check({tag, " fault"}, 32'(acc_fault), 32'(flt));
        check({tag, " mem_en"}, 32'(mem_en), 32'(!flt));
        check({tag, " wb_en"}, 32'(wb_en), 32'(wbe));
        check("R9 mem_we", 32'(mem_we), 32'(!flt && st));
        if (!flt) begin
            check({tag, " addr"}, mem_addr, ad);
            if (wbe) check({tag, " wb_value"}, wb_value, sm);
            check("R8 be", 32'(mem_be), 32'(exp_be(sz, s)));
            if (st) check("R9 wdata", mem_wdata, exp_wd(sz, wd));
        end
        @(negedge clk);
        req_valid = 1'b0;
        rd = $urandom();
        mem_rdata = rd;
        #1;
        check("R10 ld_valid", 32'(ld_valid), 32'(!flt && !st));
        if (!flt && !st) check("R10 ld_data", ld_data, exp_ld(sz, s, rd));
    endtask

    task automatic do_reset(input logic strap);
        @(negedge clk);
        rst_n = 1'b0; be_strap = strap; req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; order_be = strap;
        #1;
        check("R1 ld_valid", 32'(ld_valid), 32'h0);
        check("R1 mem_en", 32'(mem_en), 32'h0);
        check("R1 wb_en", 32'(wb_en), 32'h0);
        check("R1 fault", 32'(acc_fault), 32'h0);
    endtask

    task automatic random_ops(input int n);
        for (int i = 0; i < n; i++) begin
            logic [1:0] md;
            md = 2'($urandom_range(0, 3));
            do_op(md == 2'd0 ? "R2" : md == 2'd1 ? "R3" : md == 2'd2 ? "R4" : "R7",
                  1'($urandom()), 2'($urandom_range(0, 3)), md, 1'($urandom()), 1'($urandom()),
                  12'($urandom()), {28'h0, 4'($urandom())}, 5'($urandom_range(0, 3)),
                  $urandom(), $urandom());
        end
    endtask

    initial begin
        void'($urandom(32'd20240607));
        do_reset(1'b0);
        // Indexing modes with immediate offsets
        do_op("R2", 1'b0, 2'd2, 2'd0, 1'b0, 1'b0, 12'hffc, 32'h0, 5'd0, 32'h0000_1000, 32'h0);
        do_op("R2", 1'b1, 2'd2, 2'd0, 1'b1, 1'b0, 12'h004, 32'h0, 5'd0, 32'h0000_0000, 32'hdead_beef);
        do_op("R3", 1'b0, 2'd0, 2'd1, 1'b0, 1'b0, 12'h004, 32'h0, 5'd0, 32'h0000_0103, 32'h0);
        do_op("R4", 1'b1, 2'd1, 2'd2, 1'b1, 1'b0, 12'h002, 32'h0, 5'd0, 32'h0000_0204, 32'h1234_abcd);
        // Register offset with scaling
        do_op("R5", 1'b0, 2'd2, 2'd0, 1'b0, 1'b1, 12'h0, 32'h0000_0003, 5'd2, 32'h0000_0100, 32'h0);
        do_op("R5", 1'b0, 2'd0, 2'd2, 1'b0, 1'b1, 12'h0, 32'h0000_0005, 5'd1, 32'h0000_0101, 32'h0);
        do_op("R5", 1'b0, 2'd1, 2'd0, 1'b0, 1'b1, 12'h0, 32'h0000_0002, 5'd1, 32'h0000_0100, 32'h0);
        do_op("R5", 1'b0, 2'd1, 2'd0, 1'b0, 1'b1, 12'h0, 32'h0000_0002, 5'd0, 32'h0000_0100, 32'h0);
        // Misaligned and illegal encodings
        do_op("R6", 1'b1, 2'd1, 2'd2, 1'b0, 1'b0, 12'h001, 32'h0, 5'd0, 32'h0000_0100, 32'h0);
        do_op("R6", 1'b0, 2'd2, 2'd1, 1'b0, 1'b0, 12'h004, 32'h0, 5'd0, 32'h0000_0102, 32'h0);
        do_op("R7", 1'b0, 2'd3, 2'd0, 1'b0, 1'b0, 12'h000, 32'h0, 5'd0, 32'h0000_0100, 32'h0);
        do_op("R7", 1'b1, 2'd0, 2'd3, 1'b0, 1'b0, 12'h000, 32'h0, 5'd0, 32'h0000_0100, 32'h0);
        // Every byte lane and both halfword positions, little-endian
        for (int k = 0; k < 4; k++)
            do_op("R8", k[0], 2'd0, 2'd0, 1'b0, 1'b0, 12'(k), 32'h0, 5'd0, 32'h0000_0200, 32'h0000_00a5);
        do_op("R8", 1'b0, 2'd1, 2'd0, 1'b0, 1'b0, 12'h002, 32'h0, 5'd0, 32'h0000_0200, 32'h0);
        random_ops(400);

        do_reset(1'b1);
        for (int k = 0; k < 4; k++)
            do_op("R8", k[0], 2'd0, 2'd0, 1'b0, 1'b0, 12'(k), 32'h0, 5'd0, 32'h0000_0300, 32'h0000_005a);
        do_op("R8", 1'b0, 2'd1, 2'd0, 1'b0, 1'b0, 12'h000, 32'h0, 5'd0, 32'h0000_0300, 32'h0);
        do_op("R8", 1'b1, 2'd1, 2'd0, 1'b0, 1'b0, 12'h002, 32'h0, 5'd0, 32'h0000_0300, 32'h0000_c3d4);
        // Strap toggled outside reset: R11 expects byte order unchanged
        @(negedge clk);
        be_strap = 1'b0;
        do_op("R11", 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 12'h000, 32'h0, 5'd0, 32'h0000_0400, 32'h0);
        do_op("R11", 1'b0, 2'd1, 2'd0, 1'b0, 1'b0, 12'h002, 32'h0, 5'd0, 32'h0000_0400, 32'h0);
        random_ops(400);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule